// File: doc/BRIEF.md
# Clock-Crossing Slot FIFO with Phase-Offset Alignment

This block carries a stream of 32-bit I/Q sample pairs from a write clock domain, where the data arrives, to a read clock domain on the converter side. Storage is a ring of eight slots. A write pointer and a read pointer each step one slot per cycle of their own clock and wrap from slot 7 to slot 0. Because both sides move at the same average rate, the distance between the pointers stays fixed. That distance sets the crossing latency and the margin against the two pointers colliding.

An alignment operation sets that distance. It reloads the write pointer so that the gap equals a programmable offset, which is four slots by default. An alignment is requested by a rising edge on a software request line or by a rising edge on a frame input. Two policies are available. Immediate alignment reloads the write pointer as soon as the trigger has been captured. Deferred alignment holds the trigger pending until the read pointer, as seen from the write side, enters slot 0, so that every device sharing the same clocks reloads at the same read phase.

The write side reports the current gap as a thermometer code. It also keeps two sticky warning flags, one for pointers that are too close and one for pointers that are too far apart, and software clears each flag by writing a one to it.

Top module: `slot_xfer_fifo`

## Requirements
- R1: Eight slots of one 32-bit word each. Both pointers advance one slot per clock of their own domain and wrap from slot 7 to slot 0. With identical clocks, `rd_data` after a read edge equals the word sampled on `wr_data` (offset − 2) write edges earlier, where 2 is the synchroniser depth.
- R2: The gap is the write pointer minus the read pointer, modulo 8. The read pointer is seen in the write domain through a two-stage Gray-coded synchroniser. `occ_therm` bit i is 1 exactly when the gap is greater than i. After reset, with identical free-running clocks, the gap reads 0x03.
- R3: An alignment reloads the write pointer so that the reported gap afterwards equals `cfg_offset`. For example, offset 4 reads 0x0F and offset 5 reads 0x1F.
- R4: With `cfg_mode` = 1 (immediate), the reload happens on the third write edge after the edge that first captures the trigger. For a request first sampled on edge c, `sw_ack` is visible after edge c+3.
- R5: With `cfg_mode` = 0 (deferred), the reload waits for the first edge, no earlier than c+3, on which the synchronised read pointer is 7, so that the read side is entering slot 0. When both domains leave a common reset together, this is the first such edge whose index modulo 8 is 1.
- R6: `sw_ack` goes to 1 when an alignment started by `sw_req` completes. It returns to 0 on the third write edge after `sw_req` falls. A frame-started alignment never sets it.
- R7: Every rising edge of `frame_in` that is held for at least one write clock starts a new alignment, each using the offset present at that time.
- R8: Changing `cfg_offset` without a trigger leaves the gap and the data latency unchanged.
- R9: `warn_near_empty` is sticky. It sets when the gap is 0 or 1, and a gap of 0 means the pointers collide.
- R10: `warn_near_full` is sticky. It sets when the gap is 7.
- R11: `warn_clr` bit 0 clears the near-empty flag and bit 1 clears the near-full flag. If the condition is still present in the same cycle, setting wins over clearing.
- R12: Neither warning flag sets before the first alignment after reset.
- R13: While reset is asserted, `sw_ack`, both warning flags and `occ_therm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high write-domain reset |
| wr_data | input | 32 | Sample pair written every write cycle (I in the upper half) |
| frame_in | input | 1 | Hardware alignment trigger, asynchronous |
| sw_req | input | 1 | Software alignment request, asynchronous level |
| cfg_mode | input | 1 | 0 = deferred to read slot 0, 1 = immediate |
| cfg_offset | input | 3 | Target pointer gap loaded on alignment |
| warn_clr | input | 2 | Write-one-to-clear: bit 0 near-empty, bit 1 near-full |
| sw_ack | output | 1 | Software alignment completed |
| occ_therm | output | 8 | Thermometer-coded pointer gap |
| warn_near_empty | output | 1 | Sticky flag, gap 1 or less |
| warn_near_full | output | 1 | Sticky flag, gap 7 |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high read-domain reset |
| rd_data | output | 32 | Sample pair read from the slot under the read pointer |

## Verification
The hardest behaviour to expose is the deferred policy, because the reload looks exactly like an immediate one unless the trigger arrives at a read phase far from slot 0. The bench counts write edges from a common reset, so it always knows the read phase. It raises the request when that phase is 4, which puts the deferred reload two edges later than the immediate one, and it predicts the exact edge on which the acknowledge appears. The collision case (offset 0) and the set-beats-clear case of the warning flags are reached by frame-triggered realignments with chosen offsets. A scoreboard confirms the resulting data latency for each offset.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

    localparam int PTR_W  = 3;
    localparam int SLOTS  = 1 << PTR_W;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [SLOTS-1:0] therm_t;

    typedef enum logic {
        MODE_DATA_RATE = 1'b0,
        MODE_FIFO_RATE = 1'b1
    } align_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] i_part;
        logic [HALF_W-1:0] q_part;
    } iq_pair_t;

    typedef struct packed {
        logic near_empty;
        logic near_full;
    } warn_t;

    function automatic ptr_t bin_to_gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray_to_bin(input ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int k = PTR_W - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

    function automatic therm_t gap_to_therm(input ptr_t gap);
        therm_t t;
        for (int k = 0; k < SLOTS; k++) begin
            t[k] = (k < int'(gap));
        end
        return t;
    endfunction

endpackage

// File: rtl/sxf_cdc_sync.sv
module sxf_cdc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sxf_slot_ram.sv
module sxf_slot_ram
    import sxf_pkg::*;
(
    input  logic     wr_clk,
    input  logic     wr_rst,
    input  ptr_t     wr_slot,
    input  iq_pair_t wr_word,
    input  logic     rd_clk,
    input  logic     rd_rst,
    input  ptr_t     rd_slot,
    output iq_pair_t rd_word
);

    iq_pair_t slot_q [SLOTS];

    always_ff @(posedge wr_clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (wr_rst)
                slot_q[s] <= '0;
            else if (wr_slot == ptr_t'(s))
                slot_q[s] <= wr_word;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) rd_word <= '0;
        else        rd_word <= slot_q[rd_slot];
    end

endmodule

// File: rtl/sxf_align_ctrl.sv
module sxf_align_ctrl
    import sxf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_raw,
    input  logic        req_raw,
    input  align_mode_e mode,
    input  ptr_t        rd_seen,
    output logic        load,
    output logic        ack
);

    localparam int   TRIG_W    = 2;
    localparam ptr_t LAST_SLOT = ptr_t'(SLOTS - 1);

    // bit 0: frame, bit 1: software request
    logic [TRIG_W-1:0] trig_s;
    logic [TRIG_W-1:0] trig_d;
    logic [TRIG_W-1:0] trig_rise;
    logic              pending;
    logic              pend_sw;

    sxf_cdc_sync #(.W(TRIG_W), .STAGES(SYNC_STAGES)) u_trig_sync (
        .clk (clk),
        .rst (rst),
        .d   ({req_raw, frame_raw}),
        .q   (trig_s)
    );

    assign trig_rise = trig_s & ~trig_d;

    // Deferred policy waits until the read side is about to enter slot 0.
    assign load = pending &&
                  ((mode == MODE_FIFO_RATE) || (rd_seen == LAST_SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_d  <= '0;
            pending <= 1'b0;
            pend_sw <= 1'b0;
            ack     <= 1'b0;
        end else begin
            trig_d  <= trig_s;
            pending <= (|trig_rise) | (pending & ~load);
            pend_sw <= trig_rise[1] | (pend_sw & ~load);
            if (!trig_s[1])
                ack <= 1'b0;
            else if (load && pend_sw)
                ack <= 1'b1;
        end
    end

endmodule

// File: rtl/slot_xfer_fifo.sv
module slot_xfer_fifo
    import sxf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_in,
    input  logic              sw_req,
    input  logic              cfg_mode,
    input  logic [PTR_W-1:0]  cfg_offset,
    input  logic [1:0]        warn_clr,
    output logic              sw_ack,
    output logic [SLOTS-1:0]  occ_therm,
    output logic              warn_near_empty,
    output logic              warn_near_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic [WORD_W-1:0] rd_data
);

    localparam ptr_t LAST_SLOT = ptr_t'(SLOTS - 1);
    localparam ptr_t ONE_SLOT  = ptr_t'(1);

    // ---------------- read domain ----------------
    ptr_t     rd_ptr;
    ptr_t     rd_gray;
    iq_pair_t rd_word;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_ptr  <= '0;
            rd_gray <= '0;
        end else begin
            rd_ptr  <= ptr_t'(rd_ptr + ONE_SLOT);
            rd_gray <= bin_to_gray(ptr_t'(rd_ptr + ONE_SLOT));
        end
    end

    // ---------------- write domain ----------------
    ptr_t  wr_ptr;
    ptr_t  rd_gray_seen;
    ptr_t  rd_seen;
    ptr_t  gap;
    logic  load;
    logic  aligned;
    logic  hit_low;
    logic  hit_high;
    warn_t warn_q;

    sxf_cdc_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rd_ptr_sync (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_gray),
        .q   (rd_gray_seen)
    );

    assign rd_seen = gray_to_bin(rd_gray_seen);

    sxf_align_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_align (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .frame_raw (frame_in),
        .req_raw   (sw_req),
        .mode      (align_mode_e'(cfg_mode)),
        .rd_seen   (rd_seen),
        .load      (load),
        .ack       (sw_ack)
    );

    assign gap      = ptr_t'(wr_ptr - rd_seen);
    assign hit_low  = aligned && (gap <= ONE_SLOT);
    assign hit_high = aligned && (gap == LAST_SLOT);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_ptr  <= '0;
            aligned <= 1'b0;
            warn_q  <= '0;
        end else begin
            if (load)
                wr_ptr <= ptr_t'(rd_seen + ONE_SLOT + cfg_offset);
            else
                wr_ptr <= ptr_t'(wr_ptr + ONE_SLOT);
            aligned           <= aligned | load;
            warn_q.near_empty <= hit_low  | (warn_q.near_empty & ~warn_clr[0]);
            warn_q.near_full  <= hit_high | (warn_q.near_full  & ~warn_clr[1]);
        end
    end

    assign occ_therm       = gap_to_therm(gap);
    assign warn_near_empty = warn_q.near_empty;
    assign warn_near_full  = warn_q.near_full;

    // ---------------- storage ----------------
    sxf_slot_ram u_ram (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_slot (wr_ptr),
        .wr_word (iq_pair_t'(wr_data)),
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_slot (rd_ptr),
        .rd_word (rd_word)
    );

    assign rd_data = rd_word;

endmodule

// File: rtl/sxf_checker.sv
module sxf_checker
    import sxf_pkg::*;
(
    input logic             wr_clk,
    input logic             wr_rst,
    input logic             rd_clk,
    input logic             rd_rst,
    input ptr_t             wr_ptr,
    input ptr_t             rd_ptr,
    input ptr_t             rd_seen,
    input logic             load,
    input logic             aligned,
    input logic             cfg_mode,
    input logic [PTR_W-1:0] cfg_offset,
    input logic             sw_ack,
    input logic [1:0]       warn_clr,
    input logic [SLOTS-1:0] occ_therm,
    input logic             warn_near_empty,
    input logic             warn_near_full
);

    localparam ptr_t LAST_SLOT = ptr_t'(SLOTS - 1);

    // R1: read pointer steps one slot per read clock, wrapping
    p_rd_step_r1: assert property (@(posedge rd_clk) disable iff (rd_rst)
        1'b1 |=> rd_ptr == ptr_t'($past(rd_ptr) + ptr_t'(1)));

    // R1: write pointer steps one slot when no alignment reloads it
    p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !load |=> wr_ptr == ptr_t'($past(wr_ptr) + ptr_t'(1)));

    // R2: readback is always a thermometer shape
    p_therm_shape_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (occ_therm & (occ_therm + 1'b1)) == '0);

    // R3: reload places the write pointer offset slots past the next read position
    p_load_offset_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        load |=> wr_ptr == ptr_t'($past(rd_seen) + ptr_t'(1) + $past(cfg_offset)));

    // R5: deferred reload only as the read side enters slot 0
    p_deferred_slot0_r5: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (load && !cfg_mode) |-> rd_seen == LAST_SLOT);

    // R6: acknowledge rises only from a completed reload
    p_ack_source_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(sw_ack) |-> $past(load));

    // R9: near-empty holds until cleared
    p_empty_sticky_r9: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (warn_near_empty && !warn_clr[0]) |=> warn_near_empty);

    // R10: gap of seven raises near-full
    p_full_set_r10: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (aligned && ptr_t'(wr_ptr - rd_seen) == LAST_SLOT) |=> warn_near_full);

    // R12: flags stay low until the first alignment
    p_unarmed_r12: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !aligned |-> (!warn_near_empty && !warn_near_full));

endmodule

bind slot_xfer_fifo sxf_checker u_sxf_checker (
    .wr_clk          (wr_clk),
    .wr_rst          (wr_rst),
    .rd_clk          (rd_clk),
    .rd_rst          (rd_rst),
    .wr_ptr          (wr_ptr),
    .rd_ptr          (rd_ptr),
    .rd_seen         (rd_seen),
    .load            (load),
    .aligned         (aligned),
    .cfg_mode        (cfg_mode),
    .cfg_offset      (cfg_offset),
    .sw_ack          (sw_ack),
    .warn_clr        (warn_clr),
    .occ_therm       (occ_therm),
    .warn_near_empty (warn_near_empty),
    .warn_near_full  (warn_near_full)
);

// File: tb/slot_xfer_fifo_test.sv
module slot_xfer_fifo_test;
    import sxf_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] wr_data;
    logic        frame_in;
    logic        sw_req;
    logic        cfg_mode;
    logic [2:0]  cfg_offset;
    logic [1:0]  warn_clr;
    logic        sw_ack;
    logic [7:0]  occ_therm;
    logic        warn_near_empty;
    logic        warn_near_full;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    slot_xfer_fifo uut (
        .wr_clk          (clk),
        .wr_rst          (rst),
        .wr_data         (wr_data),
        .frame_in        (frame_in),
        .sw_req          (sw_req),
        .cfg_mode        (cfg_mode),
        .cfg_offset      (cfg_offset),
        .warn_clr        (warn_clr),
        .sw_ack          (sw_ack),
        .occ_therm       (occ_therm),
        .warn_near_empty (warn_near_empty),
        .warn_near_full  (warn_near_full),
        .rd_clk          (clk),
        .rd_rst          (rst),
        .rd_data         (rd_data)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cnt;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (rst) cnt <= 0;
        else     cnt <= cnt + 1;
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------- scoreboard ----------
    logic [31:0] sent_q[$];
    logic [31:0] sample_ctr = 32'h0000_1000;
    int          lag = -1;

    task automatic drive_word();
        sample_ctr = sample_ctr + 32'd1;
        wr_data    = sample_ctr;
        sent_q.push_back(sample_ctr);
    endtask

    initial begin
        wr_data = '0;
        forever begin
            @(negedge clk);
            drive_word();
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && lag >= 0 && sent_q.size() > lag)
                check_eq("R1 data latency", rd_data, sent_q[sent_q.size() - 1 - lag]);
            while (sent_q.size() > 16) void'(sent_q.pop_front());
        end
    end

    // ---------- helpers ----------
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_in = 1'b1;
        @(negedge clk);
        frame_in = 1'b0;
    endtask

    task automatic watch_data(input int d);
        lag = d;
        cycles(16);
        lag = -1;
    endtask

    task automatic realign_frame(input logic [2:0] off);
        cfg_offset = off;
        pulse_frame();
        cycles(10);
    endtask

    task automatic wait_ack(output int seen);
        int waited = 0;
        while (!sw_ack && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        seen = cnt;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    // ---------- main sequence ----------
    initial begin
        int c;
        int seen;
        int exp_e;

        rst = 1'b1; frame_in = 1'b0; sw_req = 1'b0;
        cfg_mode = 1'b0; cfg_offset = 3'd4; warn_clr = 2'b00;
        cycles(4);
        check_eq("R13 ack in reset", {31'd0, sw_ack}, 32'd0);
        check_eq("R13 therm in reset", {24'd0, occ_therm}, 32'd0);
        check_eq("R13 flags in reset", {30'd0, warn_near_full, warn_near_empty}, 32'd0);

        rst = 1'b0;
        cycles(10);
        check_eq("R2 startup gap", {24'd0, occ_therm}, 32'h03);
        check_eq("R12 flags before alignment", {30'd0, warn_near_full, warn_near_empty}, 32'd0);

        // R5: deferred software alignment, requested at read phase 4
        while (cnt % 8 != 4) @(negedge clk);
        c = cnt;
        sw_req = 1'b1;
        exp_e = c + 3;
        while (exp_e % 8 != 1) exp_e++;
        wait_ack(seen);
        check_eq("R5 deferred ack edge", seen, exp_e + 1);
        cycles(10);
        check_eq("R3 gap offset 4", {24'd0, occ_therm}, 32'h0F);
        watch_data(2);
        sw_req = 1'b0;
        cycles(3);
        check_eq("R6 ack clears", {31'd0, sw_ack}, 32'd0);

        // R4: immediate software alignment at the same phase
        cfg_mode = 1'b1; cfg_offset = 3'd5;
        cycles(2);
        while (cnt % 8 != 4) @(negedge clk);
        c = cnt;
        sw_req = 1'b1;
        wait_ack(seen);
        check_eq("R4 immediate ack edge", seen, c + 4);
        cycles(10);
        check_eq("R3 gap offset 5", {24'd0, occ_therm}, 32'h1F);
        watch_data(3);
        sw_req = 1'b0;
        cycles(4);

        // R8: offset change alone has no effect
        cfg_offset = 3'd2;
        cycles(12);
        check_eq("R8 gap unchanged", {24'd0, occ_therm}, 32'h1F);
        watch_data(3);

        // R7: each frame pulse realigns
        realign_frame(3'd3);
        check_eq("R7 first frame gap", {24'd0, occ_therm}, 32'h07);
        watch_data(1);
        realign_frame(3'd6);
        check_eq("R7 second frame gap", {24'd0, occ_therm}, 32'h3F);
        check_eq("R6 no ack from frame", {31'd0, sw_ack}, 32'd0);
        watch_data(4);
        check_eq("R9 R10 flags clear so far", {30'd0, warn_near_full, warn_near_empty}, 32'd0);

        // R9: near-empty
        realign_frame(3'd1);
        check_eq("R2 gap one", {24'd0, occ_therm}, 32'h01);
        check_eq("R9 near-empty set", {31'd0, warn_near_empty}, 32'd1);
        check_eq("R10 near-full idle", {31'd0, warn_near_full}, 32'd0);
        realign_frame(3'd4);
        check_eq("R9 near-empty sticky", {31'd0, warn_near_empty}, 32'd1);
        warn_clr = 2'b01;
        @(negedge clk);
        warn_clr = 2'b00;
        cycles(2);
        check_eq("R11 near-empty cleared", {31'd0, warn_near_empty}, 32'd0);

        // R10: near-full, R11 set wins over clear
        realign_frame(3'd7);
        check_eq("R2 gap seven", {24'd0, occ_therm}, 32'h7F);
        check_eq("R10 near-full set", {31'd0, warn_near_full}, 32'd1);
        check_eq("R9 near-empty stays low", {31'd0, warn_near_empty}, 32'd0);
        warn_clr = 2'b10;
        @(negedge clk);
        warn_clr = 2'b00;
        cycles(2);
        check_eq("R11 set wins", {31'd0, warn_near_full}, 32'd1);

        // R9: collision
        realign_frame(3'd0);
        check_eq("R2 gap zero", {24'd0, occ_therm}, 32'h00);
        check_eq("R9 collision flagged", {31'd0, warn_near_empty}, 32'd1);
        realign_frame(3'd4);
        warn_clr = 2'b11;
        @(negedge clk);
        warn_clr = 2'b00;
        cycles(2);
        check_eq("R11 both cleared", {30'd0, warn_near_full, warn_near_empty}, 32'd0);
        check_eq("R3 gap back to 4", {24'd0, occ_therm}, 32'h0F);

        // R5 R7: deferred alignment from a frame pulse
        cfg_mode = 1'b0;
        cfg_offset = 3'd5;
        pulse_frame();
        cycles(14);
        check_eq("R5 deferred frame gap", {24'd0, occ_therm}, 32'h1F);
        watch_data(3);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule